// File: doc/BRIEF.md
# Compare Timer with Single Output Pulse

This block is an up-counting timer that sends out one pulse for each compare event. Software programs a start value and a compare value through a small register port. It then selects the pulse mode and sets the enable bit. From that point the counter advances once per timer tick. A timer tick is either every second system clock or an externally supplied prescaler strobe, chosen by a static select input.

When the counter steps onto the compare value, three things happen:
- a sticky match flag is set;
- the interrupt line rises if the interrupt is enabled;
- the output pin leaves its programmed idle level for exactly one timer tick.

A reload bit then chooses between two behaviours. With it set, the counter restarts from the start value, which gives a periodic pulse train. With it clear, the counter runs on freely and wraps at the top of its range. Clearing the enable bit freezes the counter and returns the pin to idle at once.

Top module: `pulse_timer`

## Requirements
- R1: The timer runs only while the enable bit (control bit 0) is 1 and the mode field (control bits 7:4) holds 4'b0001. In any other state the counter holds its value and ticks have no effect.
- R2: A control write that turns the timer on from the stopped state loads the counter with the start register (address 1). The output pin then shows the idle level held in control bit 8.
- R3: The match flag (control bit 15) is set on the tick at which the counter takes the compare value (address 2). It stays set until a control write with bit 15 = 1 clears it. A new match in the same cycle as that clearing write wins, and the flag stays set.
- R4: The interrupt output equals the match flag ANDed with the interrupt-enable bit (control bit 10).
- R5: From a match tick until the next tick, the output pin shows the inverse of the idle level. It then returns to idle.
- R6: With the reload bit (control bit 9) set, the tick after a match loads the counter with the start value.
- R7: With the reload bit clear, the counter increments on every tick after a match, and wraps from 24'hFFFFFF to 0.
- R8: With psc_sel = 0, a tick occurs on every second clock after start: 2k clocks after the start edge the counter has advanced by k. With psc_sel = 1, only clocks with psc_tick high are ticks.
- R9: Clearing the enable bit freezes the counter and drives the pin to the idle level from the next cycle. This applies even when a pulse is in progress.
- R10: rdata is combinational from addr: 0 gives control, 1 gives the start value, 2 gives the compare value, 3 gives the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| psc_sel | input | 1 | Tick source: 0 = clock/2, 1 = prescaler strobe |
| psc_tick | input | 1 | Prescaler strobe |
| tmr_out | output | 1 | Pulse output pin |
| irq | output | 1 | Compare interrupt |

## Verification
The match event that sets the flag and the software write that clears it can fall in the same clock. The bench provokes this by raising a prescaler strobe that moves the counter onto the compare value during the same cycle as a control write with bit 15 set. The test passes if the flag and the interrupt both remain high afterwards. A second collision is a disable write that lands while a pulse is active. Here the pin must already be back at idle in the very next sample.

// File: rtl/pulse_timer.sv
module pulse_timer #(
  parameter int CW = 24,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          psc_sel,
  input  logic          psc_tick,
  output logic          tmr_out,
  output logic          irq
);
  localparam logic [3:0] MODE_PULSE = 4'b0001;

  logic          en, inv, rm, ie, flag, pulse, div;
  logic [3:0]    mode;
  logic [CW-1:0] load_q, cmp_q, cnt;

  wire wr_ctrl = wr_en && addr == 2'd0;
  wire run     = en && mode == MODE_PULSE;
  wire start   = wr_ctrl && wdata[0] && wdata[7:4] == MODE_PULSE && !run;
  wire tick    = run && (psc_sel ? psc_tick : div);
  wire [CW-1:0] nxt = (rm && cnt == cmp_q) ? load_q : cnt + 1'b1;
  wire hit     = tick && nxt == cmp_q;

  assign tmr_out = inv ^ (pulse & run);
  assign irq     = flag & ie;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en <= 1'b0; inv <= 1'b0; rm <= 1'b0; ie <= 1'b0; mode <= '0;
      load_q <= '0; cmp_q <= '0;
    end else if (wr_en) begin
      case (addr)
        2'd0: begin
          en <= wdata[0]; mode <= wdata[7:4];
          inv <= wdata[8]; rm <= wdata[9]; ie <= wdata[10];
        end
        2'd1: load_q <= wdata[CW-1:0];
        2'd2: cmp_q  <= wdata[CW-1:0];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; pulse <= 1'b0; div <= 1'b0;
    end else if (start) begin
      cnt <= load_q; pulse <= 1'b0; div <= 1'b0;
    end else if (!run) begin
      pulse <= 1'b0;
    end else begin
      div <= ~div;
      if (tick) begin
        cnt   <= nxt;
        pulse <= hit;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                      flag <= 1'b0;
    else if (hit)                    flag <= 1'b1;
    else if (wr_ctrl && wdata[15])   flag <= 1'b0;

  always_comb begin
    rdata = '0;
    case (addr)
      2'd0: begin
        rdata[0] = en; rdata[7:4] = mode; rdata[8] = inv;
        rdata[9] = rm; rdata[10] = ie; rdata[15] = flag;
      end
      2'd1: rdata[CW-1:0] = load_q;
      2'd2: rdata[CW-1:0] = cmp_q;
      default: rdata[CW-1:0] = cnt;
    endcase
  end

  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !start |=> $stable(cnt));
  p_match_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick && cnt != cmp_q && nxt == cmp_q |=> flag && cnt == cmp_q);
  p_flag_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    flag && !(wr_ctrl && wdata[15]) |=> flag);
  p_pulse_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse && tick && nxt != cmp_q |=> !pulse);
  p_reload_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tick && rm && cnt == cmp_q |=> cnt == $past(load_q));
  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !(rm && cnt == cmp_q) |=> cnt == CW'($past(cnt) + 1'b1));
  p_div_pace_r8: assert property (@(posedge clk) disable iff (!rst_n)
    run && !psc_sel && tick |=> !tick);
endmodule

// File: tb/pulse_timer_test.sv
module pulse_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, psc_sel = 1'b1, psc_tick = 1'b0;
  logic [1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic tmr_out, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pulse_timer uut (.clk, .rst_n, .wr_en, .addr, .wdata, .rdata,
                   .psc_sel, .psc_tick, .tmr_out, .irq);

  function automatic logic [31:0] ctl(bit e, bit [3:0] m, bit iv, bit r, bit ien, bit clr);
    return {16'd0, clr, 4'd0, ien, r, iv, m, 3'd0, e};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic tk();
    @(negedge clk); psc_tick = 1'b1;
    @(negedge clk); psc_tick = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(2'd0, v); chk("R10 ctrl reset", v, 0);
    rd(2'd3, v); chk("R10 cnt reset", v, 0);
    chk("R2 out reset", tmr_out, 0);
    chk("R4 irq reset", irq, 0);
  endtask

  task automatic t_reload();
    logic [31:0] v;
    wr(2'd1, 5); wr(2'd2, 7);
    wr(2'd0, ctl(1, 4'b0001, 1, 1, 1, 0));
    chk("R2 idle level", tmr_out, 1);
    rd(2'd3, v); chk("R2 start load", v, 5);
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk("R8 no strobe no step", v, 5);
    tk(); rd(2'd3, v); chk("R10 cnt 6", v, 6);
    chk("R5 no pulse yet", tmr_out, 1);
    tk(); rd(2'd3, v); chk("R3 cnt at cmp", v, 7);
    chk("R5 pulse active", tmr_out, 0);
    chk("R4 irq on match", irq, 1);
    rd(2'd0, v); chk("R3 flag set", v[15], 1);
    tk(); rd(2'd3, v); chk("R6 reload", v, 5);
    chk("R5 pulse one tick", tmr_out, 1);
    chk("R3 flag sticky", irq, 1);
    wr(2'd0, ctl(1, 4'b0001, 1, 1, 1, 1));
    chk("R3 w1c clears", irq, 0);
    rd(2'd3, v); chk("R3 w1c no restart", v, 5);
    tk(); tk();
    chk("R6 second pulse", tmr_out, 0);
    wr(2'd0, ctl(0, 4'b0001, 1, 1, 1, 0));
    chk("R9 idle on disable", tmr_out, 1);
    tk(); rd(2'd3, v); chk("R9 frozen", v, 7);
  endtask

  task automatic t_free();
    logic [31:0] v;
    wr(2'd1, 32'hFFFFFD); wr(2'd2, 32'hFFFFFE);
    wr(2'd0, ctl(1, 4'b0001, 0, 0, 0, 1));
    chk("R2 idle low", tmr_out, 0);
    tk(); chk("R5 pulse high", tmr_out, 1);
    chk("R4 irq masked", irq, 0);
    rd(2'd0, v); chk("R3 flag masked irq", v[15], 1);
    tk(); rd(2'd3, v); chk("R7 past match", v, 32'hFFFFFF);
    chk("R5 pulse ends", tmr_out, 0);
    tk(); rd(2'd3, v); chk("R7 wrap", v, 0);
    tk(); rd(2'd3, v); chk("R7 after wrap", v, 1);
    wr(2'd0, 0);
  endtask

  task automatic t_mode();
    logic [31:0] v;
    wr(2'd1, 3);
    wr(2'd0, ctl(1, 4'b0010, 0, 0, 0, 1));
    rd(2'd0, v); chk("R1 ctrl readback", v, 32'h21);
    tk(); tk(); tk();
    rd(2'd3, v); chk("R1 other mode holds", v, 1);
    chk("R1 out idle", tmr_out, 0);
    wr(2'd0, 0);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    wr(2'd1, 0); wr(2'd2, 1);
    wr(2'd0, ctl(1, 4'b0001, 0, 0, 1, 1));
    @(negedge clk); psc_tick = 1'b1; wr_en = 1'b1; addr = 2'd0;
    wdata = ctl(1, 4'b0001, 0, 0, 1, 1);
    @(negedge clk); psc_tick = 1'b0; wr_en = 1'b0;
    rd(2'd3, v); chk("R3 collide cnt", v, 1);
    chk("R3 match beats clear", irq, 1);
    wr(2'd0, ctl(0, 4'b0001, 0, 0, 1, 1));
  endtask

  task automatic t_div();
    logic [31:0] v;
    psc_sel = 1'b0;
    wr(2'd1, 10); wr(2'd2, 100);
    addr = 2'd0; wdata = ctl(1, 4'b0001, 0, 0, 0, 0);
    @(negedge clk); wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
    repeat (6) @(negedge clk);
    rd(2'd3, v); chk("R8 clk/2 pace", v, 13);
    wr(2'd0, 0);
    psc_sel = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset(); t_reload(); t_free(); t_mode(); t_collide(); t_div();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule